// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches virtual-to-physical page mappings in a small, fully associative array. Every entry carries its own page size as a base-two logarithm, so small and large pages can sit side by side. A combinational lookup port compares a virtual address against all entries at once. On a hit it returns the physical address and an uncacheable flag. It also returns a page-fault flag, worked out from the access privilege, the access kind and a global write-protect control.

Refills come in on a valid/ready insert port. When the array is full, the entry that was stamped longest ago is replaced. Stamps come from a free-running sequence counter. An entry is stamped when it is inserted, and again when a lookup hits it with the recency flag set. A maintenance command input can clear every entry, clear only the entries not marked global, or remove the one entry that covers a given virtual address.

Top module: `fa_tlb`

## Requirements
- R1: After reset no entry is valid. A lookup that misses drives hit, fault and uncacheable low and the physical address to zero.
- R2: An accepted insert takes the lowest-indexed free entry. It stamps that entry with the current sequence value, and the counter then advances. A hitting lookup with the recency flag set also stamps its entry. If both happen in the same cycle, the lookup takes the lower value.
- R3: With no free entry, an insert replaces the entry holding the smallest stamp. On equal stamps, the lowest index is replaced.
- R4: An insert whose virtual address already hits an entry leaves every entry and the counter unchanged.
- R5: An entry matches when the virtual bits at and above its page-size log agree. The physical address is the entry base ORed with the virtual bits below that size.
- R6: Maintenance code 1 clears every entry. Code 2 clears only the entries whose global bit is 0. Code 0 does nothing.
- R7: Maintenance code 3 clears the entry that hits the given virtual address. Entries covering other pages are left alone.
- R8: An access is user-mode when the privilege field equals 3 and the supervisor-override input is 0. A write is bad when the page is not writable and the access is user-mode or write protect is on. A hit faults on a user-mode access to a non-user page, or on a bad write.
- R9: A store-check probe (lk_store_probe=1, lk_write=0) faults exactly when the same access as a write would be a bad write.
- R10: The entry's uncacheable attribute appears on lk_uncache when the lookup hits.
- R11: ins_ready is low in any cycle with a nonzero maintenance code, and an insert is never accepted in such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request present |
| lk_touch | input | 1 | Restamp the hit entry (recency update) |
| lk_vaddr | input | AW | Lookup virtual address |
| lk_priv | input | 2 | Access privilege level, 3 = least privileged |
| lk_sup_ovr | input | 1 | Treat the access as supervisor regardless of level |
| lk_write | input | 1 | Access is a write |
| lk_store_probe | input | 1 | Read that must fault as if it were a write |
| wp_en | input | 1 | Write protect also applies to supervisor accesses |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | AW | Translated physical address |
| lk_fault | output | 1 | Page fault indication |
| lk_uncache | output | 1 | Hit page is uncacheable |
| ins_valid | input | 1 | Refill request |
| ins_ready | output | 1 | Refill can be accepted this cycle |
| ins_vaddr | input | AW | Refill virtual address (any address in the page) |
| ins_pbase | input | AW | Refill physical page address |
| ins_lg | input | LW | Refill page-size log2 |
| ins_writable | input | 1 | Page writable |
| ins_user | input | 1 | Page reachable from user mode |
| ins_global | input | 1 | Page survives the non-global flush |
| ins_uncache | input | 1 | Page uncacheable |
| mnt_cmd | input | 2 | 0 idle, 1 clear all, 2 clear non-global, 3 clear one page |
| mnt_vaddr | input | AW | Address for the one-page clear |

## Verification
The assertions take for granted that no refill uses a page-size log below MIN_LG. They also assume the mapped pages never overlap, so at most one entry can cover any address. The low-bit pass-through and the one-page clear check both rest on these two points. The stimulus uses only 4 KiB and 4 MiB pages at distinct, size-aligned places. Nothing is refilled into a region that a live entry already covers, except the deliberate duplicate refill, which is rejected.

// File: rtl/fa_tlb_pkg.sv
package fa_tlb_pkg;
  typedef enum logic [1:0] {
    MNT_IDLE  = 2'd0,
    MNT_ALL   = 2'd1,
    MNT_LOCAL = 2'd2,
    MNT_PAGE  = 2'd3
  } mnt_cmd_e;

  typedef struct packed {
    logic writable;
    logic user;
    logic global;
    logic uncache;
  } pg_attr_t;
endpackage

// File: rtl/fa_tlb_match.sv
module fa_tlb_match #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 5
) (
  input  logic          vld,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] lg,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] lo_mask
);
  logic [AW-1:0] ones;
  logic [AW-1:0] hi_mask;

  assign ones    = '1;
  assign hi_mask = ones << lg;
  assign lo_mask = ~hi_mask;
  assign hit     = vld && (((addr ^ base) & hi_mask) == '0);
endmodule

// File: rtl/fa_tlb_victim.sv
module fa_tlb_victim #(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [SW-1:0] stamp [N],
  output logic [IW-1:0] idx
);
  logic          got_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] old_idx;
  logic [SW-1:0] old_stamp;

  always_comb begin
    got_free  = 1'b0;
    free_idx  = '0;
    old_idx   = '0;
    old_stamp = stamp[0];
    for (int i = 0; i < N; i++) begin
      if (!vld[i] && !got_free) begin
        got_free = 1'b1;
        free_idx = IW'(i);
      end
      if (stamp[i] < old_stamp) begin
        old_stamp = stamp[i];
        old_idx   = IW'(i);
      end
    end
    idx = got_free ? free_idx : old_idx;
  end
endmodule

// File: rtl/fa_tlb_perm.sv
module fa_tlb_perm (
  input  logic       hit,
  input  logic       writable,
  input  logic       user_pg,
  input  logic [1:0] priv,
  input  logic       sup_ovr,
  input  logic       write,
  input  logic       probe,
  input  logic       wp_en,
  output logic       fault
);
  logic user_mode;
  logic bad_write;

  assign user_mode = (priv == 2'd3) && !sup_ovr;
  assign bad_write = !writable && (user_mode || wp_en);
  assign fault     = hit && ((user_mode && !user_pg) || ((write || probe) && bad_write));
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
  import fa_tlb_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 5,
  parameter int unsigned SW = 32,
  parameter int unsigned MIN_LG = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic          lk_touch,
  input  logic [AW-1:0] lk_vaddr,
  input  logic [1:0]    lk_priv,
  input  logic          lk_sup_ovr,
  input  logic          lk_write,
  input  logic          lk_store_probe,
  input  logic          wp_en,
  output logic          lk_hit,
  output logic [AW-1:0] lk_paddr,
  output logic          lk_fault,
  output logic          lk_uncache,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [AW-1:0] ins_vaddr,
  input  logic [AW-1:0] ins_pbase,
  input  logic [LW-1:0] ins_lg,
  input  logic          ins_writable,
  input  logic          ins_user,
  input  logic          ins_global,
  input  logic          ins_uncache,
  input  logic [1:0]    mnt_cmd,
  input  logic [AW-1:0] mnt_vaddr
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // entry storage
  logic [N-1:0]  vld_q, vld_d;
  logic [AW-1:0] vb_q [N], vb_d [N];
  logic [AW-1:0] pb_q [N], pb_d [N];
  logic [LW-1:0] lg_q [N], lg_d [N];
  pg_attr_t      at_q [N], at_d [N];
  logic [SW-1:0] st_q [N], st_d [N];
  logic [SW-1:0] seq_q, seq_d;

  // match arrays: lookup port and probe port (insert or one-page clear)
  logic [N-1:0]  lk_hv, pr_hv;
  logic [AW-1:0] lk_lo [N];
  logic [AW-1:0] pr_lo [N];
  logic [AW-1:0] pr_addr;
  mnt_cmd_e      cmd;

  assign cmd     = mnt_cmd_e'(mnt_cmd);
  assign pr_addr = (cmd == MNT_PAGE) ? mnt_vaddr : ins_vaddr;

  for (genvar g = 0; g < N; g++) begin : g_ent
    fa_tlb_match #(.AW(AW), .LW(LW)) u_lk (
      .vld(vld_q[g]), .base(vb_q[g]), .lg(lg_q[g]), .addr(lk_vaddr),
      .hit(lk_hv[g]), .lo_mask(lk_lo[g]));
    fa_tlb_match #(.AW(AW), .LW(LW)) u_pr (
      .vld(vld_q[g]), .base(vb_q[g]), .lg(lg_q[g]), .addr(pr_addr),
      .hit(pr_hv[g]), .lo_mask(pr_lo[g]));
  end

  // lookup result: lowest-indexed hit wins
  logic [IW-1:0] sel;
  logic          any_hit;
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lk_hv[i]) begin
        sel     = IW'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign lk_hit     = lk_valid && any_hit;
  assign lk_paddr   = lk_hit ? (pb_q[sel] | (lk_vaddr & lk_lo[sel])) : '0;
  assign lk_uncache = lk_hit && at_q[sel].uncache;

  fa_tlb_perm u_perm (
    .hit(lk_hit), .writable(at_q[sel].writable), .user_pg(at_q[sel].user),
    .priv(lk_priv), .sup_ovr(lk_sup_ovr), .write(lk_write),
    .probe(lk_store_probe), .wp_en(wp_en), .fault(lk_fault));

  // replacement choice
  logic [IW-1:0] vic;
  fa_tlb_victim #(.N(N), .SW(SW)) u_vic (.vld(vld_q), .stamp(st_q), .idx(vic));

  // next state
  logic          touch, ins_go;
  logic [AW-1:0] ins_hi;
  assign ins_ready = (cmd == MNT_IDLE);
  assign touch     = lk_hit && lk_touch;
  assign ins_go    = ins_valid && ins_ready && (pr_hv == '0);
  assign ins_hi    = {AW{1'b1}} << ins_lg;

  always_comb begin
    vld_d = vld_q;
    vb_d  = vb_q;
    pb_d  = pb_q;
    lg_d  = lg_q;
    at_d  = at_q;
    st_d  = st_q;
    seq_d = seq_q + SW'(touch) + SW'(ins_go);
    if (touch) st_d[sel] = seq_q;
    if (ins_go) begin
      vld_d[vic] = 1'b1;
      vb_d[vic]  = ins_vaddr & ins_hi;
      pb_d[vic]  = ins_pbase & ins_hi;
      lg_d[vic]  = ins_lg;
      at_d[vic]  = '{writable: ins_writable, user: ins_user,
                     global: ins_global, uncache: ins_uncache};
      st_d[vic]  = seq_q + SW'(touch);
    end
    for (int i = 0; i < N; i++) begin
      case (cmd)
        MNT_ALL:   vld_d[i] = 1'b0;
        MNT_LOCAL: if (!at_q[i].global) vld_d[i] = 1'b0;
        MNT_PAGE:  if (pr_hv[i]) vld_d[i] = 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= '0;
      seq_q <= '0;
      for (int i = 0; i < N; i++) begin
        vb_q[i] <= '0;
        pb_q[i] <= '0;
        lg_q[i] <= '0;
        at_q[i] <= '0;
        st_q[i] <= '0;
      end
    end else begin
      vld_q <= vld_d;
      seq_q <= seq_d;
      vb_q  <= vb_d;
      pb_q  <= pb_d;
      lg_q  <= lg_d;
      at_q  <= at_d;
      st_q  <= st_d;
    end
  end
endmodule

// File: rtl/fa_tlb_chk.sv
module fa_tlb_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned MIN_LG = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic [AW-1:0] lk_vaddr,
  input logic          lk_hit,
  input logic [AW-1:0] lk_paddr,
  input logic          lk_fault,
  input logic          lk_uncache,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic [1:0]    mnt_cmd,
  input logic [AW-1:0] mnt_vaddr
);
  a_r1_hit_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  a_r5_low_bits_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[MIN_LG-1:0] == lk_vaddr[MIN_LG-1:0]));

  a_r6_clear_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_cmd == 2'd1) |=> !lk_hit);

  a_r7_page_clear_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_cmd == 2'd3) |=> !(lk_hit && (lk_vaddr == $past(mnt_vaddr))));

  a_r8_fault_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  a_r10_uncache_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_uncache |-> lk_hit);

  a_r11_no_refill_in_maint: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_cmd != 2'd0) |-> !ins_ready);
endmodule

bind fa_tlb fa_tlb_chk #(.AW(AW), .MIN_LG(MIN_LG)) u_chk (.*);

// File: tb/fa_tlb_tb.sv
module fa_tlb_tb;
  localparam int AW = 32;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 0, lk_touch = 0, lk_sup_ovr = 0, lk_write = 0;
  logic          lk_store_probe = 0, wp_en = 0;
  logic [AW-1:0] lk_vaddr = '0;
  logic [1:0]    lk_priv = '0;
  logic          lk_hit, lk_fault, lk_uncache, ins_ready;
  logic [AW-1:0] lk_paddr;
  logic          ins_valid = 0, ins_writable = 0, ins_user = 0, ins_global = 0;
  logic          ins_uncache = 0;
  logic [AW-1:0] ins_vaddr = '0, ins_pbase = '0, mnt_vaddr = '0;
  logic [LW-1:0] ins_lg = '0;
  logic [1:0]    mnt_cmd = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fa_tlb u_dut (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  priv;
    logic        ovr;
    logic        wr;
    logic        probe;
    logic        wp;
    logic        hit;
    logic [31:0] pa;
    logic        flt;
    logic        unc;
  } vec_t;

  // lookup table against entries A (4K, user rw), B (4M, user ro, global), C (4K, sup rw, uncached)
  localparam vec_t VECS [11] = '{
    '{32'h0000_1234, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0008_0234, 1'b0, 1'b0},
    '{32'h0052_3456, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0812_3456, 1'b0, 1'b0},
    '{32'h0052_3456, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0812_3456, 1'b1, 1'b0},
    '{32'h0052_3456, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0812_3456, 1'b0, 1'b0},
    '{32'h0052_3456, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0812_3456, 1'b1, 1'b0},
    '{32'h0052_3456, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0812_3456, 1'b1, 1'b0},
    '{32'h0052_3456, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0812_3456, 1'b0, 1'b0},
    '{32'h0000_3010, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h000A_0010, 1'b1, 1'b1},
    '{32'h0000_3010, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h000A_0010, 1'b0, 1'b1},
    '{32'h0000_2000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0},
    '{32'h0080_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ins(input logic [31:0] va, input logic [31:0] pa, input logic [4:0] lg,
                     input logic w, input logic u, input logic gl, input logic unc);
    @(negedge clk);
    ins_valid = 1; ins_vaddr = va; ins_pbase = pa; ins_lg = lg;
    ins_writable = w; ins_user = u; ins_global = gl; ins_uncache = unc;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic maint(input logic [1:0] c, input logic [31:0] va, input string req);
    @(negedge clk);
    mnt_cmd = c; mnt_vaddr = va;
    #1 check(req, {63'd0, ins_ready}, 64'd0);
    @(negedge clk);
    mnt_cmd = 2'd0;
  endtask

  // lookup with all checks; result packed as {hit, fault, uncache, paddr}
  task automatic look(input logic [31:0] va, input logic [1:0] pr, input logic ovr,
                      input logic wr, input logic pb, input logic wp, input logic tch,
                      input logic [34:0] exp, input string req);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va; lk_priv = pr; lk_sup_ovr = ovr;
    lk_write = wr; lk_store_probe = pb; wp_en = wp; lk_touch = tch;
    #1 check(req, {29'd0, lk_hit, lk_fault, lk_uncache, lk_paddr}, {29'd0, exp});
    if (tch) @(negedge clk);
    lk_valid = 0; lk_touch = 0; lk_write = 0; lk_store_probe = 0;
  endtask

  function automatic logic [34:0] hitpa(input logic [31:0] pa);
    return {3'b100, pa};
  endfunction

  localparam logic [34:0] MISS = 35'd0;

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: empty after reset, misses drive zeros
    look(32'h0000_1000, 2'd0, 0, 0, 0, 0, 0, MISS, "R1 reset miss");

    ins(32'h0000_1000, 32'h0008_0000, 5'd12, 1, 1, 0, 0); // A idx0 stamp0
    ins(32'h0040_0000, 32'h0800_0000, 5'd22, 0, 1, 1, 0); // B idx1 stamp1
    ins(32'h0000_3000, 32'h000A_0000, 5'd12, 1, 0, 0, 1); // C idx2 stamp2

    // table: R5 sizes and paddr, R8 faults, R9 probe, R10 uncacheable
    for (int i = 0; i < 11; i++) begin
      look(VECS[i].va, VECS[i].priv, VECS[i].ovr, VECS[i].wr, VECS[i].probe,
           VECS[i].wp, 0, {VECS[i].hit, VECS[i].flt, VECS[i].unc, VECS[i].pa},
           $sformatf("R5 R8 R9 R10 vector %0d", i));
    end

    // R4: refill of a page already present keeps the old mapping
    ins(32'h0000_1800, 32'h0009_0000, 5'd12, 1, 1, 0, 0);
    look(32'h0000_1004, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h0008_0004), "R4 duplicate kept");

    // R2: next refill takes the free slot idx3 stamp3
    ins(32'h0000_5000, 32'h000C_0000, 5'd12, 1, 1, 0, 0);
    look(32'h0000_5008, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h000C_0008), "R2 free slot used");

    // R2: touching A restamps it; R3: next refill evicts B (stamp1)
    look(32'h0000_1000, 2'd0, 0, 0, 0, 0, 1, hitpa(32'h0008_0000), "R2 touch hit");
    ins(32'h0000_7000, 32'h000E_0000, 5'd12, 1, 1, 0, 0);
    look(32'h0052_3456, 2'd0, 0, 0, 0, 0, 0, MISS, "R3 oldest evicted");
    look(32'h0000_1000, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h0008_0000), "R3 touched entry kept");
    look(32'h0000_7abc, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h000E_0abc), "R3 new entry");
    look(32'h0000_5000, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h000C_0000), "R3 other entry kept");

    // R3: next eviction takes C (stamp2) for a global large page
    ins(32'h0040_0000, 32'h0800_0000, 5'd22, 1, 1, 1, 0);
    look(32'h0000_3010, 2'd0, 0, 0, 0, 0, 0, MISS, "R3 second eviction");

    // R6: non-global clear spares the global page; R11 ready low
    maint(2'd2, 32'h0, "R11 ready low on clear non-global");
    look(32'h0040_0010, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h0800_0010), "R6 global survives");
    look(32'h0000_1000, 2'd0, 0, 0, 0, 0, 0, MISS, "R6 non-global cleared A");
    look(32'h0000_5000, 2'd0, 0, 0, 0, 0, 0, MISS, "R6 non-global cleared");

    // R7: one-page clear by any address inside the page
    ins(32'h0000_9000, 32'h0001_0000, 5'd12, 1, 1, 0, 0);
    maint(2'd3, 32'h0041_2345, "R11 ready low on page clear");
    look(32'h0040_0010, 2'd0, 0, 0, 0, 0, 0, MISS, "R7 page cleared");
    look(32'h0000_9004, 2'd0, 0, 0, 0, 0, 0, hitpa(32'h0001_0004), "R7 other page kept");

    // R11: refill held during maintenance is not taken in that cycle
    @(negedge clk);
    mnt_cmd = 2'd1; ins_valid = 1; ins_vaddr = 32'h0000_B000; ins_pbase = 32'h0002_0000;
    ins_lg = 5'd12; ins_writable = 1; ins_user = 1; ins_global = 1; ins_uncache = 0;
    @(negedge clk);
    mnt_cmd = 2'd0; ins_valid = 0;
    // R6: clear-all removed everything, R11: blocked refill absent
    look(32'h0000_9004, 2'd0, 0, 0, 0, 0, 0, MISS, "R6 clear all");
    look(32'h0000_B000, 2'd0, 0, 0, 0, 0, 0, MISS, "R11 refill blocked");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule